// File: doc/BRIEF.md
# Parallel ADC Register Access Sequencer

This block carries out register reads and writes on the 16-bit bidirectional parallel port of a multichannel sampling ADC. The host starts an access with a 2-bit control word plus an address and a write byte. The sequencer then generates chip select, the active-low write strobe, the active-low read strobe and an active-high tri-state release for the data pins. It drives the outgoing bus word and samples the byte the converter returns. The pad buffers sit outside the block. It receives `pin_tri` and `pin_dout` and returns only the low byte of the pins on `pin_din`.

A write takes one write-strobe cycle. A read takes two bus cycles. First comes a write-strobe request that carries the address. Then, after a turnaround cycle, a read-strobe data phase follows, and in it the device drives the byte. Chip select stays low for the whole register session. The session ends when the host requests an exit. The block then sends a write-strobe word with a zero address field, which puts the converter back in conversion-read mode, and chip select rises.

There is no back-pressure in either direction. A control word is taken only when `busy` is low, and any word offered while `busy` is high is dropped. The read result sits on `rd_byte` when `done` pulses for one cycle and stays there until the next read completes. The host must be ready to take it in that cycle, because nothing stalls the sequencer.

Top module: `padc_reg_seq`

## Requirements
- R1: After reset and while no session is open: `pin_cs_n`, `pin_wr_n`, `pin_rd_n` and `pin_tri` are 1, and `busy` and `done` are 0.
- R2: When `busy` is low, a clock edge with `host_ctrl[0]`=1 accepts an access. `host_ctrl[1]`=1 selects a read and 0 selects a write. `busy` is 1 from the next cycle until the cycle in which `done` is 1.
- R3: The bus word has bit 15 as the access flag (1 = read request, 0 = write or exit, polarity set by `READ_FLAG`), bits 14:8 as the address and bits 7:0 as the data. A read request carries data 8'h00.
- R4: A write drives its word (`pin_tri`=0) through one write strobe. That strobe is low for `LOW_CYC` cycles and then high for `HIGH_CYC` cycles before the access completes.
- R5: A read gives exactly one write-strobe request and then exactly one read strobe, `LOW_CYC` cycles long. `pin_tri` is 1 during the read strobe, in the cycle before it and in the cycle after it.
- R6: The read result is `pin_din[7:0]` as sampled in the last low cycle of the read strobe. It appears on `rd_byte` in the cycle in which `done` is 1.
- R7: `done` is a single-cycle pulse at the end of every access and exit, and `busy` is 0 in that cycle.
- R8: `pin_cs_n` stays 0 from the first accepted access through all later accesses until the exit completes.
- R9: `host_exit`=1 in an open session with `busy` low sends one write strobe with the word 16'h0000. `pin_cs_n` then goes to 1 in the cycle in which `done` is 1.
- R10: Control words offered while `busy` is high cause no bus cycle. `host_exit` outside a session or while busy has no effect. When `host_ctrl[0]` and `host_exit` arrive together, the access is taken and the exit is dropped.
- R11: `pin_wr_n` and `pin_rd_n` are never low together, and neither is low while `pin_cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_ctrl | input | 2 | Bit 0 starts an access, bit 1 = read (1) / write (0) |
| host_addr | input | 7 | Register address for the access |
| host_wdata | input | 8 | Byte to write |
| host_exit | input | 1 | Request to end the register session |
| busy | output | 1 | Access or exit in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_byte | output | 8 | Last byte read from the device |
| pin_cs_n | output | 1 | Chip select, active low |
| pin_wr_n | output | 1 | Write strobe, active low |
| pin_rd_n | output | 1 | Read strobe, active low |
| pin_tri | output | 1 | Data pin release, 1 = pins not driven |
| pin_dout | output | 16 | Word driven onto the data pins |
| pin_din | input | 8 | Low byte of the data pins as received |

## Verification
The accesses come from a seeded random mix of reads and writes to addresses 1..127. A device model holds its own register array, so a write followed by a read of the same address shows whether the packed word and the sampled byte line up. The device puts a fixed non-matching pattern on the bus outside read strobes. Because of that, a read sampled in the wrong cycle gives a different byte. Directed cases cover several points: control words during a busy write, an exit request with no open session, an access and an exit offered in the same cycle, and sessions closed and reopened. Each case separates the ignore, priority and chip-select rules from plain access sequencing.

// File: rtl/padc_pkg.sv
package padc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,   // no session, chip select high
    ST_SESS,   // session open, waiting
    ST_WLO,    // write strobe low, word driven
    ST_WHI,    // write strobe high, word held
    ST_TA1,    // turnaround before read strobe
    ST_RLO,    // read strobe low, pins released
    ST_TA2,    // turnaround after read strobe
    ST_XLO,    // exit word, strobe low
    ST_XHI     // exit word, strobe high
  } seq_st_t;

  function automatic logic st_busy(input seq_st_t s);
    return !(s == ST_IDLE || s == ST_SESS);
  endfunction

  function automatic logic st_drives(input seq_st_t s);
    return (s == ST_WLO) || (s == ST_WHI) || (s == ST_XLO) || (s == ST_XHI);
  endfunction

endpackage

// File: rtl/padc_phase_timer.sv
module padc_phase_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/padc_word_pack.sv
module padc_word_pack #(
  parameter int   AW        = 7,
  parameter int   DW        = 8,
  parameter logic READ_FLAG = 1'b1,
  localparam int  BW        = 1 + AW + DW
) (
  input  logic          is_exit,
  input  logic          is_read,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic [BW-1:0] word
);
  always_comb begin
    if (is_exit)      word = {~READ_FLAG, {AW{1'b0}}, {DW{1'b0}}};
    else if (is_read) word = { READ_FLAG, addr, {DW{1'b0}}};
    else              word = {~READ_FLAG, addr, data};
  end
endmodule

// File: rtl/padc_rd_capture.sv
module padc_rd_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= din;
  end
endmodule

// File: rtl/padc_reg_seq.sv
module padc_reg_seq
  import padc_pkg::*;
#(
  parameter int   AW        = 7,
  parameter int   DW        = 8,
  parameter int   LOW_CYC   = 2,
  parameter int   HIGH_CYC  = 2,
  parameter logic READ_FLAG = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          host_ctrl,
  input  logic [AW-1:0]       host_addr,
  input  logic [DW-1:0]       host_wdata,
  input  logic                host_exit,
  output logic                busy,
  output logic                done,
  output logic [DW-1:0]       rd_byte,
  output logic                pin_cs_n,
  output logic                pin_wr_n,
  output logic                pin_rd_n,
  output logic                pin_tri,
  output logic [AW+DW:0]      pin_dout,
  input  logic [DW-1:0]       pin_din
);
  localparam int BW   = 1 + AW + DW;
  localparam int MAXC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LO_LD = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] HI_LD = CW'(HIGH_CYC - 1);

  seq_st_t       st, nxt;
  logic          last, ld;
  logic [CW-1:0] ld_val;
  logic          op_rd;
  logic          take_acc, take_exit;
  logic [BW-1:0] word_q, word_new;

  // acceptance: access has priority over exit
  assign take_acc  = !st_busy(st) && host_ctrl[0];
  assign take_exit = (st == ST_SESS) && host_exit && !host_ctrl[0];

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE, ST_SESS: begin
        if (take_acc)       nxt = ST_WLO;
        else if (take_exit) nxt = ST_XLO;
      end
      ST_WLO: if (last) nxt = ST_WHI;
      ST_WHI: if (last) nxt = op_rd ? ST_TA1 : ST_SESS;
      ST_TA1: nxt = ST_RLO;
      ST_RLO: if (last) nxt = ST_TA2;
      ST_TA2: nxt = ST_SESS;
      ST_XLO: if (last) nxt = ST_XHI;
      ST_XHI: if (last) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign ld = (nxt != st);

  always_comb begin
    unique case (nxt)
      ST_WLO, ST_RLO, ST_XLO: ld_val = LO_LD;
      ST_WHI, ST_XHI:         ld_val = HI_LD;
      default:                ld_val = '0;
    endcase
  end

  padc_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .last     (last)
  );

  padc_word_pack #(.AW(AW), .DW(DW), .READ_FLAG(READ_FLAG)) u_pack (
    .is_exit (!take_acc),
    .is_read (host_ctrl[1]),
    .addr    (host_addr),
    .data    (host_wdata),
    .word    (word_new)
  );

  padc_rd_capture #(.DW(DW)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .en    ((st == ST_RLO) && last),
    .din   (pin_din),
    .q     (rd_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      op_rd    <= 1'b0;
      word_q   <= '0;
      pin_cs_n <= 1'b1;
      pin_wr_n <= 1'b1;
      pin_rd_n <= 1'b1;
      pin_tri  <= 1'b1;
      done     <= 1'b0;
    end else begin
      st <= nxt;
      if (take_acc) op_rd <= host_ctrl[1];
      if (take_acc || take_exit) word_q <= word_new;
      // pin levels follow the next state so they change on the same edge
      pin_cs_n <= (nxt == ST_IDLE);
      pin_wr_n <= !((nxt == ST_WLO) || (nxt == ST_XLO));
      pin_rd_n <= (nxt != ST_RLO);
      pin_tri  <= !st_drives(nxt);
      done     <= st_busy(st) && !st_busy(nxt);
    end
  end

  assign busy     = st_busy(st);
  assign pin_dout = word_q;
endmodule

// File: rtl/padc_reg_seq_chk.sv
module padc_reg_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic pin_cs_n,
  input logic pin_wr_n,
  input logic pin_rd_n,
  input logic pin_tri
);
  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!pin_wr_n && !pin_rd_n));

  assert_strobe_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_wr_n || !pin_rd_n) |-> !pin_cs_n);

  assert_rd_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_rd_n |-> pin_tri);

  assert_rd_turn_in_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_rd_n) |-> $past(pin_tri));

  assert_rd_turn_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_rd_n) |-> pin_tri);

  assert_wr_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_wr_n |-> !pin_tri);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind padc_reg_seq padc_reg_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .pin_cs_n (pin_cs_n),
  .pin_wr_n (pin_wr_n),
  .pin_rd_n (pin_rd_n),
  .pin_tri  (pin_tri)
);

// File: tb/padc_reg_seq_tb.sv
`timescale 1ns/1ps
module padc_reg_seq_tb;
  localparam int LOW_CYC  = 2;
  localparam int HIGH_CYC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  host_ctrl = '0;
  logic [6:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_exit = 1'b0;
  logic        busy, done;
  logic [7:0]  rd_byte;
  logic        pin_cs_n, pin_wr_n, pin_rd_n, pin_tri;
  logic [15:0] pin_dout;
  logic [7:0]  pin_din;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  padc_reg_seq #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_ctrl(host_ctrl), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_exit(host_exit), .busy(busy), .done(done),
    .rd_byte(rd_byte), .pin_cs_n(pin_cs_n), .pin_wr_n(pin_wr_n),
    .pin_rd_n(pin_rd_n), .pin_tri(pin_tri), .pin_dout(pin_dout), .pin_din(pin_din)
  );

  // ---------------- device model ----------------
  logic [7:0]  dev_mem [128];
  logic [7:0]  exp_mem [128];
  logic [6:0]  dev_addr = '0;
  logic [15:0] cap_word = '0, last_wr = '0;
  int wr_cnt = 0, rd_cnt = 0, wr_run = 0, rd_run = 0;
  logic prev_wr = 1'b1, prev_rd = 1'b1, prev_tri = 1'b1;

  assign pin_din = (!pin_rd_n) ? dev_mem[dev_addr] : 8'h5A ^ dev_mem[dev_addr];

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 37 + 11);
  endfunction

  function automatic logic [15:0] exp_word(input bit rd, input logic [6:0] a,
                                           input logic [7:0] d);
    return rd ? {1'b1, a, 8'h00} : {1'b0, a, d};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!pin_wr_n) begin
        wr_run++;
        cap_word = pin_dout;
        chk(!pin_tri, "R4 word driven during write strobe", pin_tri, 0);
        chk(!pin_cs_n, "R11 cs low under write strobe", pin_cs_n, 0);
      end else if (!prev_wr) begin
        wr_cnt++;
        last_wr = cap_word;
        chk(wr_run == LOW_CYC, "R4 write strobe low length", wr_run, LOW_CYC);
        wr_run = 0;
        if (cap_word[15] == 1'b0 && cap_word[14:8] != 0)
          dev_mem[cap_word[14:8]] = cap_word[7:0];
        dev_addr = cap_word[14:8];
      end
      if (!pin_rd_n) begin
        rd_run++;
        chk(pin_tri, "R5 pins released during read strobe", pin_tri, 1);
        chk(!pin_cs_n, "R11 cs low under read strobe", pin_cs_n, 0);
        chk(pin_wr_n, "R11 strobes exclusive", pin_wr_n, 1);
        if (prev_rd) chk(prev_tri, "R5 turnaround before read", prev_tri, 1);
      end else if (!prev_rd) begin
        rd_cnt++;
        chk(rd_run == LOW_CYC, "R5 read strobe low length", rd_run, LOW_CYC);
        chk(pin_tri, "R5 turnaround after read", pin_tri, 1);
        rd_run = 0;
      end
      prev_wr = pin_wr_n; prev_rd = pin_rd_n; prev_tri = pin_tri;
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 200) begin tick(); n++; end
    chk(done, tag, done, 1);
  endtask

  task automatic do_acc(input bit rd, input logic [6:0] a, input logic [7:0] d,
                        input bit with_exit);
    int w0, r0;
    while (busy) tick();
    w0 = wr_cnt; r0 = rd_cnt;
    host_ctrl = {rd, 1'b1}; host_addr = a; host_wdata = d; host_exit = with_exit;
    tick();
    host_ctrl = 2'b00; host_exit = 1'b0;
    chk(busy, "R2 busy after accept", busy, 1);
    wait_done("R7 done at end of access");
    chk(!busy, "R7 busy low with done", busy, 0);
    chk(last_wr == exp_word(rd, a, d), "R3 bus word", last_wr, exp_word(rd, a, d));
    chk(wr_cnt == w0 + 1, "R5 one write-strobe cycle per access", wr_cnt - w0, 1);
    chk(rd_cnt == r0 + (rd ? 1 : 0), "R5 read strobe count", rd_cnt - r0, rd ? 1 : 0);
    if (rd) chk(rd_byte == exp_mem[a], "R6 read byte", rd_byte, exp_mem[a]);
    else exp_mem[a] = d;
    chk(!pin_cs_n, "R8 cs held low in session", pin_cs_n, 0);
    tick();
    chk(!done, "R7 done single cycle", done, 0);
  endtask

  task automatic do_exit();
    int w0;
    while (busy) tick();
    w0 = wr_cnt;
    host_exit = 1'b1;
    tick();
    host_exit = 1'b0;
    chk(busy, "R9 busy during exit", busy, 1);
    wait_done("R9 done after exit");
    chk(pin_cs_n, "R9 cs high at exit done", pin_cs_n, 1);
    chk(wr_cnt == w0 + 1, "R9 one exit strobe", wr_cnt - w0, 1);
    chk(last_wr == 16'h0000, "R9 exit word", last_wr, 0);
    tick();
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int seed_dummy;
    for (int i = 0; i < 128; i++) begin
      dev_mem[i] = init_val(i);
      exp_mem[i] = init_val(i);
    end
    seed_dummy = $urandom(32'h1F2E3D4C);
    repeat (3) tick();
    chk(pin_cs_n && pin_wr_n && pin_rd_n && pin_tri, "R1 pins idle in reset",
        {pin_cs_n, pin_wr_n, pin_rd_n, pin_tri}, 4'hF);
    rst_n = 1'b1;
    repeat (2) tick();
    chk(!busy && !done, "R1 busy and done low after reset", {busy, done}, 0);
    chk(pin_cs_n && pin_tri, "R1 no session after reset", {pin_cs_n, pin_tri}, 2'b11);

    // R10: exit with no session is ignored
    begin
      int w0 = wr_cnt;
      host_exit = 1'b1; tick(); host_exit = 1'b0;
      repeat (8) tick();
      chk(wr_cnt == w0 && pin_cs_n && !busy, "R10 exit outside session ignored",
          wr_cnt - w0, 0);
    end

    // directed: write then read back same address
    do_acc(1'b0, 7'h12, 8'hA7, 1'b0);
    do_acc(1'b1, 7'h12, 8'h00, 1'b0);
    do_acc(1'b1, 7'h7F, 8'h00, 1'b0);

    // R10: control words while busy are dropped
    begin
      int w0;
      while (busy) tick();
      w0 = wr_cnt;
      host_ctrl = 2'b01; host_addr = 7'h33; host_wdata = 8'h11; tick();
      host_wdata = 8'hEE;
      host_ctrl = 2'b01; tick();
      host_ctrl = 2'b11; host_exit = 1'b1; tick();
      host_ctrl = 2'b00; host_exit = 1'b0;
      wait_done("R10 first write completes");
      exp_mem[7'h33] = 8'h11;
      repeat (6) tick();
      chk(wr_cnt == w0 + 1, "R10 words during busy ignored", wr_cnt - w0, 1);
      chk(!pin_cs_n, "R10 exit during busy ignored", pin_cs_n, 0);
      do_acc(1'b1, 7'h33, 8'h00, 1'b0);
    end

    // R10: access and exit together -> access wins, session stays open
    do_acc(1'b0, 7'h05, 8'h3C, 1'b1);
    repeat (3) tick();
    chk(!pin_cs_n, "R10 access beats exit", pin_cs_n, 0);

    do_exit();
    chk(pin_cs_n && !busy, "R1 idle after exit", {pin_cs_n, busy}, 2'b10);

    // random mix over several sessions
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 20; k++) begin
        bit rd = 1'($urandom_range(0, 1));
        logic [6:0] a = 7'($urandom_range(1, 127));
        logic [7:0] d = 8'($urandom);
        do_acc(rd, a, rd ? 8'h00 : d, 1'b0);
        if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 5)) tick();
      end
      do_exit();
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule